// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Block Memory

This block is a main-memory model built from four independent banks. Consecutive word addresses land in consecutive banks, so the four words of one cache block sit in four different banks at the same row. A block request names any word of the block. All four banks then start their access together, and the words come back one per cycle over a single word-wide response bus. The first word returned is the one that was named, and the rest follow in ascending bank order with wrap-around. With the banks overlapping their access, a four-word block costs one address cycle, one bank access and four transfer cycles, instead of four full bank accesses.

A requester issues a block request whenever the busy flag is low. It then collects four response beats, each tagged with the word's position inside the block. Single-word writes go straight to one bank. A write keeps only that bank occupied for a full bank cycle, so the other banks stay free.

Each bank is a behavioural array. Its bank cycle time is set by a parameter (default 10 cycles). A bank cannot begin a new access until its previous access has run for that many cycles.

Top module: `banked_block_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `rsp_valid` and every bit of `bank_busy` are low.
- R2: Word address bits [1:0] pick the bank and the remaining upper bits pick the row. After reset, word address a holds the value 0x5A000000 + a.
- R3: A block request is accepted on a rising edge where `req_valid` is high and `busy` is low. It returns exactly the four words of the aligned block containing `req_addr` (the addresses with bits [1:0] replaced by 0..3). Each beat carries its own data and, on `rsp_idx`, its word address bits [1:0].
- R4: The first beat is the requested word. Each following beat is the next bank up, wrapping from 3 to 0.
- R5: When all banks are idle at acceptance, the first beat is on the response bus in the cycle after the 10th rising edge following the accepting edge. The other three beats follow on the next three consecutive cycles, so a block takes 15 cycles counting the request cycle.
- R6: `busy` is high from the accepting edge until the last beat is presented. It drops in the cycle of the last beat. A request made while `busy` is high is ignored and produces no beats.
- R7: An accepted single-word write changes the stored word, and a later block read returns the new value.
- R8: A write is accepted when `wr_valid` is high, `busy` and `req_valid` are low, and the target bank's `bank_busy` bit is low. From the next cycle that bank's `bank_busy` bit stays high for 9 cycles, and the other banks' bits are unaffected. A second write to the same bank is therefore accepted exactly 10 cycles after the first.
- R9: A write is ignored, leaving memory unchanged, if its bank is busy, if `busy` is high, or if a block request is presented in the same cycle.
- R10: If a bank is still in a write's cycle when a block is accepted, the other banks keep the R5 timing. The occupied bank starts its read on the edge where its cycle ends, and its word can be presented 10 cycles after that start. The beat order of R4 is kept, so later beats wait behind it.
- R11: Each accepted request yields exactly four `rsp_valid` beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block read request |
| req_addr | input | 6 | Word address of the requested (critical) word |
| busy | output | 1 | A block transfer is in flight; new requests are refused |
| rsp_valid | output | 1 | A response beat is on the bus this cycle |
| rsp_idx | output | 2 | Position of the beat's word inside its block |
| rsp_data | output | 32 | Data of the beat's word |
| wr_valid | input | 1 | Single-word write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Data to write |
| bank_busy | output | 4 | Per-bank flag: access in progress or waiting to start |

## Verification
Block reads are started from bank 0 and from bank 2. This separates a plain ascending order from the wrap-around order, and it checks the beat cycles against the 15-cycle idle budget. Reads issued one cycle after a write compare two cases. In one, the written bank comes last, so only the final beat is late. In the other, the written bank comes first, so every beat shifts behind it. This is what separates per-bank occupancy from a global stall. Writes are also aimed at a bank that is still in its cycle, issued during a transfer, and issued in the same cycle as a request. Readback then shows that each of those writes left memory untouched, while a write issued exactly one cycle time later does land.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    // Default geometry of the interleaved memory.
    localparam int BBM_DATA_W = 32;
    localparam int BBM_NBANK  = 4;
    localparam int BBM_ROWS   = 16;
    localparam int BBM_CYCLE  = 10;

    // Transfer sequencer state.
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    // Value held by a word right after reset, as a function of its word address.
    function automatic logic [31:0] init_word(input int unsigned waddr);
        return 32'h5A00_0000 | waddr;
    endfunction

endpackage

// File: rtl/bbm_bank.sv
module bbm_bank
    import bbm_pkg::*;
#(
    parameter int DATA_W  = BBM_DATA_W,
    parameter int ROWS    = BBM_ROWS,
    parameter int CYCLE   = BBM_CYCLE,
    parameter int NBANK   = BBM_NBANK,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int CNT_W  = $clog2(CYCLE) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              blk_start,
    input  logic [ROW_W-1:0]  blk_row,
    input  logic              take,
    output logic              bank_busy,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ROWS];
    logic [CNT_W-1:0]  cnt;       // remaining cycles of the current access
    logic              pend;      // block read waiting for the bank to free
    logic              held;      // read issued, word not yet taken
    logic [ROW_W-1:0]  row_q;
    logic              idle;

    assign idle      = (cnt == '0);
    assign bank_busy = pend || !idle;
    assign rd_ready  = held && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pend    <= 1'b0;
            held    <= 1'b0;
            row_q   <= '0;
            rd_data <= '0;
            for (int r = 0; r < ROWS; r++) begin
                mem[r] <= DATA_W'(init_word(32'(r * NBANK + BANK_ID)));
            end
        end else begin
            if (!idle) begin
                cnt <= cnt - 1'b1;
            end
            if (take) begin
                held <= 1'b0;
            end
            // Write: data lands now, the bank stays occupied for a full cycle.
            if (wr_en) begin
                mem[wr_row] <= wr_data;
                cnt         <= CNT_W'(CYCLE - 1);
            end
            // Block read: start at once if free, else queue until the cycle ends.
            if (blk_start) begin
                if (idle) begin
                    rd_data <= mem[blk_row];
                    held    <= 1'b1;
                    cnt     <= CNT_W'(CYCLE - 1);
                end else begin
                    pend  <= 1'b1;
                    row_q <= blk_row;
                end
            end else if (pend && idle) begin
                rd_data <= mem[row_q];
                held    <= 1'b1;
                pend    <= 1'b0;
                cnt     <= CNT_W'(CYCLE - 1);
            end
        end
    end

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
    import bbm_pkg::*;
#(
    parameter int NBANK  = BBM_NBANK,
    parameter int DATA_W = BBM_DATA_W,
    parameter int ROWS   = BBM_ROWS,
    localparam int SEL_W  = $clog2(NBANK),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + SEL_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [NBANK-1:0]              rdy,
    input  logic [NBANK-1:0][DATA_W-1:0]  bank_dat,
    output logic                          busy,
    output logic                          blk_start,
    output logic [ROW_W-1:0]              blk_row,
    output logic [NBANK-1:0]              take,
    output logic                          rsp_valid,
    output logic [SEL_W-1:0]              rsp_idx,
    output logic [DATA_W-1:0]             rsp_data
);

    sq_state_e        st;
    logic [SEL_W-1:0] ptr;    // bank whose word goes out next
    logic [SEL_W-1:0] left;   // beats still to send after the current one
    logic             hand;

    assign busy      = (st == SQ_RUN);
    assign blk_start = req_valid && (st == SQ_IDLE);
    assign blk_row   = req_addr[ADDR_W-1:SEL_W];
    assign hand      = (st == SQ_RUN) && rdy[ptr];

    always_comb begin
        take = '0;
        if (hand) begin
            take[ptr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            ptr       <= '0;
            left      <= '0;
            rsp_valid <= 1'b0;
            rsp_idx   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (blk_start) begin
                st   <= SQ_RUN;
                ptr  <= req_addr[SEL_W-1:0];
                left <= SEL_W'(NBANK - 1);
            end
            if (hand) begin
                rsp_valid <= 1'b1;
                rsp_idx   <= ptr;
                rsp_data  <= bank_dat[ptr];
                ptr       <= ptr + 1'b1;
                if (left == '0) begin
                    st <= SQ_IDLE;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/banked_block_mem.sv
module banked_block_mem
    import bbm_pkg::*;
#(
    parameter int NBANK  = BBM_NBANK,   // power of two; equals words per block
    parameter int DATA_W = BBM_DATA_W,
    parameter int ROWS   = BBM_ROWS,    // power of two
    parameter int CYCLE  = BBM_CYCLE,   // bank cycle time, at least 2
    localparam int SEL_W  = $clog2(NBANK),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [SEL_W-1:0]  rsp_idx,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NBANK-1:0]  bank_busy
);

    logic                         blk_start;
    logic [ROW_W-1:0]             blk_row;
    logic [NBANK-1:0]             take;
    logic [NBANK-1:0]             rdy;
    logic [NBANK-1:0][DATA_W-1:0] bank_dat;
    logic [SEL_W-1:0]             wr_sel;
    logic [ROW_W-1:0]             wr_row;
    logic                         wr_go;

    // Interleave: low address bits select the bank, upper bits the row.
    assign wr_sel = wr_addr[SEL_W-1:0];
    assign wr_row = wr_addr[ADDR_W-1:SEL_W];
    assign wr_go  = wr_valid && !busy && !req_valid && !bank_busy[wr_sel];

    bbm_seq #(
        .NBANK  (NBANK),
        .DATA_W (DATA_W),
        .ROWS   (ROWS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rdy       (rdy),
        .bank_dat  (bank_dat),
        .busy      (busy),
        .blk_start (blk_start),
        .blk_row   (blk_row),
        .take      (take),
        .rsp_valid (rsp_valid),
        .rsp_idx   (rsp_idx),
        .rsp_data  (rsp_data)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bbm_bank #(
            .DATA_W  (DATA_W),
            .ROWS    (ROWS),
            .CYCLE   (CYCLE),
            .NBANK   (NBANK),
            .BANK_ID (b)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_go && (wr_sel == SEL_W'(b))),
            .wr_row    (wr_row),
            .wr_data   (wr_data),
            .blk_start (blk_start),
            .blk_row   (blk_row),
            .take      (take[b]),
            .bank_busy (bank_busy[b]),
            .rd_ready  (rdy[b]),
            .rd_data   (bank_dat[b])
        );
    end

endmodule

// File: rtl/bbm_chk.sv
module bbm_chk #(
    parameter int NBANK = 4,
    parameter int ROWS  = 16,
    localparam int SEL_W  = $clog2(NBANK),
    localparam int ADDR_W = $clog2(ROWS) + SEL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              busy,
    input logic              rsp_valid,
    input logic [SEL_W-1:0]  rsp_idx,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NBANK-1:0]  bank_busy
);

    logic [SEL_W:0]   wcnt;
    logic [SEL_W-1:0] last_idx;
    logic [SEL_W-1:0] first_idx;
    logic             acc;
    logic             wr_take;

    assign acc     = req_valid && !busy;
    assign wr_take = wr_valid && !busy && !req_valid && !bank_busy[wr_addr[SEL_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt      <= '0;
            last_idx  <= '0;
            first_idx <= '0;
        end else begin
            if (acc) begin
                wcnt      <= '0;
                first_idx <= req_addr[SEL_W-1:0];
            end else if (rsp_valid) begin
                wcnt <= wcnt + 1'b1;
            end
            if (rsp_valid) begin
                last_idx <= rsp_idx;
            end
        end
    end

    assert_beat_in_transfer_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(busy));

    assert_busy_ends_on_beat_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);

    assert_beat_limit_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (wcnt < (SEL_W + 1)'(NBANK)));

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && wcnt == '0) |-> (rsp_idx == first_idx));

    assert_beat_order_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && wcnt != '0) |-> (rsp_idx == SEL_W'(last_idx + 1'b1)));

    assert_write_occupies_R8: assert property (@(posedge clk) disable iff (rst)
        wr_take |=> bank_busy[$past(wr_addr[SEL_W-1:0])]);

endmodule

bind banked_block_mem bbm_chk #(
    .NBANK (NBANK),
    .ROWS  (ROWS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_idx   (rsp_idx),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .bank_busy (bank_busy)
);

// File: tb/banked_block_mem_tb.sv
module banked_block_mem_tb;

    localparam int NB  = 4;
    localparam int DW  = 32;
    localparam int AW  = 6;
    localparam int CYC = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          busy;
    logic          rsp_valid;
    logic [1:0]    rsp_idx;
    logic [DW-1:0] rsp_data;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [NB-1:0] bank_busy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [31:0] mirror [64];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    banked_block_mem u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_idx   (rsp_idx),
        .rsp_data  (rsp_data),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bank_busy (bank_busy)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Single-word write held for one edge; the bench decides if it should land.
    task automatic wr_word(input int a, input logic [31:0] v, input bit lands);
        wr_valid = 1'b1;
        wr_addr  = AW'(a);
        wr_data  = v;
        @(negedge clk);
        wr_valid = 1'b0;
        if (lands) mirror[a] = v;
    endtask

    // Issue a block request and check every beat. sb: bank still in a write
    // cycle (-1 none); d: edges between that write and the accepting edge.
    task automatic run_block(input int addr, input int sb, input int d,
                             input bit poke, input string tag);
        int base  = addr & ~3;
        int first = addr & 3;
        int st    = (d >= CYC) ? 0 : CYC - d;
        int t     = CYC - 1;
        int exp_t [4];
        int got   = 0;
        int acc;
        for (int k = 0; k < 4; k++) begin
            int b   = (first + k) % 4;
            int rdy = (b == sb) ? st + CYC : CYC;
            t = (rdy > t + 1) ? rdy : t + 1;
            exp_t[k] = t;
        end
        req_valid = 1'b1;
        req_addr  = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        wr_valid  = 1'b0;
        acc = cyc;
        chk(busy == 1'b1, tag, "R6 busy after accept", busy, 1);
        for (int n = 1; n <= 30; n++) begin
            if (poke && n == 3) begin
                req_valid = 1'b1;
                req_addr  = AW'(addr ^ 5);
                wr_valid  = 1'b1;
                wr_addr   = AW'(3);
                wr_data   = 32'hDEAD_0003;
            end
            if (poke && n == 4) begin
                req_valid = 1'b0;
                wr_valid  = 1'b0;
            end
            @(negedge clk);
            if (rsp_valid) begin
                if (got < 4) begin
                    int w = base + (first + got) % 4;
                    chk(cyc - acc == exp_t[got], tag, "R5/R10 beat cycle", cyc - acc, exp_t[got]);
                    chk(rsp_idx == 2'((first + got) % 4), tag, "R4 beat index", rsp_idx, (first + got) % 4);
                    chk(rsp_data == mirror[w], tag, "R3 beat data", rsp_data, mirror[w]);
                    chk(busy == (got != 3), tag, "R6 busy during beats", busy, got != 3);
                end
                got++;
            end
        end
        chk(got == 4, tag, "R11 beat count", got, 4);
        chk(busy == 1'b0, tag, "R6 busy after block", busy, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_addr = '0;
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        for (int a = 0; a < 64; a++) mirror[a] = 32'h5A00_0000 + a;
        idle_wait(3);
        chk(busy == 0 && rsp_valid == 0 && bank_busy == '0, "R1", "state in reset",
            {busy, rsp_valid, bank_busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && rsp_valid == 0 && bank_busy == '0, "R1", "state after reset",
            {busy, rsp_valid, bank_busy}, 0);
    endtask

    // R8 and R9: a write occupies one bank; a second write to it too early is dropped.
    task automatic t_write_window();
        wr_word(13, 32'hC0FF_EE13, 1);
        wr_word(5, 32'hBAD0_0005, 0);
        for (int k = 1; k <= 8; k++) begin
            chk(bank_busy == 4'b0010, "R8", "bank busy window", bank_busy, 4'b0010);
            @(negedge clk);
        end
        chk(bank_busy == 4'b0000, "R8", "bank free after cycle", bank_busy, 0);
        wr_word(1, 32'h1111_0001, 1);
        chk(bank_busy == 4'b0010, "R8", "second write taken at 10 cycles", bank_busy, 4'b0010);
        idle_wait(12);
    endtask

    initial begin
        t_reset();
        run_block(0, -1, 99, 0, "R2/R3/R4/R5 block0");
        run_block(6, -1, 99, 1, "R4/R6/R9 block6 poke");
        run_block(9, -1, 99, 0, "R3/R4 block9");
        idle_wait(4);
        t_write_window();
        run_block(0, -1, 99, 0, "R7/R9 block0 reread");
        run_block(12, -1, 99, 0, "R7 block12");
        run_block(5, -1, 99, 0, "R9 block4 dropped write");
        idle_wait(4);
        wr_word(2, 32'h2222_0002, 1);
        run_block(3, 2, 1, 0, "R10 written bank last");
        idle_wait(12);
        wr_word(10, 32'hAAAA_000A, 1);
        run_block(10, 2, 1, 0, "R10 written bank first");
        idle_wait(12);
        wr_valid = 1'b1;
        wr_addr  = AW'(14);
        wr_data  = 32'hBAD0_000E;
        run_block(14, -1, 99, 0, "R9 write with request");
        run_block(14, -1, 99, 0, "R9 write with request reread");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule